// File: doc/BRIEF.md
# Serial Overhead Byte Output Formatter

This block turns one frame's worth of section and line overhead results into a bit-serial stream. The results are captured in parallel on a load strobe: fifteen leading overhead bytes, eleven named bytes and error counts, and one zero stuff byte. Each frame carries 27 byte slots of 8 bits, which is 216 serial cycles. A one-cycle frame sync marks the first bit. A free-running serial clock enable paces the stream, and one bit is presented per enable period.

Loads are double-buffered. A snapshot taken while a frame is being shifted out waits until that frame ends. If a snapshot is waiting at the frame boundary, the next frame follows back-to-back. Any of the three alarm inputs (loss of signal, loss of frame, severely errored frame) forces sync and data low at once. The frame that is in progress, or that starts while an alarm is up, stays silent to its end, so a partial frame is never emitted. The serial clock enable is not affected by alarms.

Top module: `ovh_serial_fmt`

## Requirements
- R1: `ser_clk_en_o` pulses high for one clock in every `BIT_DIV` clocks after reset, without a break, whatever the state of the alarms.
- R2: A frame is 216 serial cycles: 27 byte slots of 8 bits each. Each byte is sent MSB first, one bit per serial cycle, and each bit is held for one whole enable period.
- R3: Slot order is as follows. Slots 1 to 15 carry `lead_bytes_i[0]` to `lead_bytes_i[14]` in index order. They are followed by d11, d12, s1, e2 and the B1 count. Next come the B2 bit count (high byte, then low byte) and the B2 block count (high byte, then low byte). Then m0 and m1, and finally slot 27, which is always 8'h00.
- R4: `ser_sync_o` is high only during the first serial cycle of an emitted frame: exactly one pulse per unsquelched frame.
- R5: A frame starts only from a snapshot captured by `load_i`. When no snapshot is waiting, sync and data stay low. A load captured on an enabled clock puts bit 1 of the frame on the outputs after the following enable.
- R6: A load during a frame does not alter the bits of that frame. If several loads arrive during a frame, the latest one wins. A waiting snapshot starts right after bit 216, with no gap.
- R7: While `los_i`, `lof_i` or `sef_i` is high, `ser_sync_o` and `ser_data_o` are 0 in that same clock.
- R8: Once an alarm has been seen, outputs stay 0 until the next frame start. A frame that starts while an alarm is high is entirely silent. A frame that starts with all alarms low is emitted normally, even if an alarm pulsed while the block was idle.
- R9: While `rst_n` is low and after reset, sync and data are 0 and no snapshot is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture all parallel inputs as the next frame's snapshot |
| lead_bytes_i | input | 15x8 | Overhead bytes for slots 1 to 15, index 0 first |
| d11_i | input | 8 | Byte for slot 16 |
| d12_i | input | 8 | Byte for slot 17 |
| s1_i | input | 8 | Byte for slot 18 |
| e2_i | input | 8 | Byte for slot 19 |
| b1_err_i | input | 8 | B1 bit error count, slot 20 |
| b2_bit_err_i | input | 16 | B2 bit error count, slots 21 (high) and 22 (low) |
| b2_blk_err_i | input | 16 | B2 block error count, slots 23 (high) and 24 (low) |
| m0_i | input | 8 | Byte for slot 25 |
| m1_i | input | 8 | Byte for slot 26 |
| los_i | input | 1 | Loss-of-signal alarm |
| lof_i | input | 1 | Loss-of-frame alarm |
| sef_i | input | 1 | Severely-errored-frame alarm |
| ser_clk_en_o | output | 1 | Serial cycle enable, free-running |
| ser_sync_o | output | 1 | Frame sync, first serial cycle of a frame |
| ser_data_o | output | 1 | Serial data |

## Verification
A bit index that is off by one, skips, or is not cleared shows up on the next enabled clock. Every later bit of the frame is then misplaced, and the following frame's sync lands at the wrong enable count. A swap of the pending and active buffers, or a lost pending flag, shows up at the next frame boundary. The symptom is a frame with the wrong content, a missing back-to-back frame, or an extra frame. A squelch flag that clears early leaks bits in the same serial cycle in which the alarm drops. A flag that sticks silences the whole following frame, including its sync.

// File: rtl/ovs_pkg.sv
// Package: shared sizes and the snapshot type of the serial overhead formatter.
// Assumes the fixed 27-slot map; only the slot count of the leading group and
// the field widths are named here, so the rest is derived.
package ovs_pkg;

    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 16;
    localparam int NUM_LEAD   = 15;
    localparam int NUM_TAIL   = 12;
    localparam int NUM_SLOTS  = NUM_LEAD + NUM_TAIL;
    localparam int FRAME_BITS = NUM_SLOTS * BYTE_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [NUM_LEAD-1:0][BYTE_W-1:0] lead;
        logic [BYTE_W-1:0]               d11;
        logic [BYTE_W-1:0]               d12;
        logic [BYTE_W-1:0]               s1;
        logic [BYTE_W-1:0]               e2;
        logic [BYTE_W-1:0]               b1;
        logic [CNT_W-1:0]                b2_bit;
        logic [CNT_W-1:0]                b2_blk;
        logic [BYTE_W-1:0]               m0;
        logic [BYTE_W-1:0]               m1;
    } ovs_snap_t;

endpackage

// File: rtl/ovs_tick_gen.sv
// Module: serial cycle enable generator.
// Produces a one-clock pulse every BIT_DIV clocks from reset on. It has no
// other input, so alarms can never stop it. BIT_DIV = 1 gives a constant enable.
module ovs_tick_gen #(
    parameter int BIT_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (BIT_DIV <= 1) begin : g_full_rate
            assign tick_o = 1'b1;
        end else begin : g_divided
            localparam int DW = $clog2(BIT_DIV);
            localparam logic [DW-1:0] LAST = DW'(BIT_DIV - 1);
            logic [DW-1:0] div_q;

            // Count clocks within one serial cycle, wrapping at BIT_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/ovs_snapshot_buf.sv
// Module: two-stage snapshot store.
// The pending stage takes every load; a later load overwrites it. The active
// stage copies the pending stage only when the sequencer takes it at a frame
// boundary, so the frame being sent never changes. Assumes take_i is only
// raised while pend_valid_o is high.
module ovs_snapshot_buf
    import ovs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  ovs_snap_t snap_i,
    input  logic      take_i,
    output logic      pend_valid_o,
    output ovs_snap_t active_o
);

    ovs_snap_t pend_q;
    ovs_snap_t act_q;
    logic      pvld_q;

    // Capture the parallel inputs on each load.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (load_i) pend_q <= snap_i;
    end

    // Track whether a snapshot is waiting; a load in the take cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      pvld_q <= 1'b0;
        else if (load_i) pvld_q <= 1'b1;
        else if (take_i) pvld_q <= 1'b0;
    end

    // Move the waiting snapshot into the frame being sent.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (take_i) act_q <= pend_q;
    end

    assign pend_valid_o = pvld_q;
    assign active_o     = act_q;

endmodule

// File: rtl/ovs_slot_map.sv
// Module: lays the active snapshot out as one 216-bit frame vector.
// Slot 1 occupies the most significant byte, so the vector's MSB is the
// first bit on the line. Purely combinational.
module ovs_slot_map
    import ovs_pkg::*;
(
    input  ovs_snap_t             snap_i,
    output logic [FRAME_BITS-1:0] frame_o
);

    logic [0:NUM_SLOTS-1][BYTE_W-1:0] slot_w;

    generate
        for (genvar k = 0; k < NUM_LEAD; k++) begin : g_lead
            assign slot_w[k] = snap_i.lead[k];
        end
    endgenerate

    assign slot_w[NUM_LEAD + 0]  = snap_i.d11;
    assign slot_w[NUM_LEAD + 1]  = snap_i.d12;
    assign slot_w[NUM_LEAD + 2]  = snap_i.s1;
    assign slot_w[NUM_LEAD + 3]  = snap_i.e2;
    assign slot_w[NUM_LEAD + 4]  = snap_i.b1;
    assign slot_w[NUM_LEAD + 5]  = snap_i.b2_bit[CNT_W-1 -: BYTE_W];
    assign slot_w[NUM_LEAD + 6]  = snap_i.b2_bit[BYTE_W-1:0];
    assign slot_w[NUM_LEAD + 7]  = snap_i.b2_blk[CNT_W-1 -: BYTE_W];
    assign slot_w[NUM_LEAD + 8]  = snap_i.b2_blk[BYTE_W-1:0];
    assign slot_w[NUM_LEAD + 9]  = snap_i.m0;
    assign slot_w[NUM_LEAD + 10] = snap_i.m1;
    assign slot_w[NUM_LEAD + 11] = '0;

    assign frame_o = slot_w;

endmodule

// File: rtl/ovs_bit_seq.sv
// Module: frame sequencer and output squelch.
// Walks a bit index across the frame once per enable. It starts a frame at
// a boundary only if a snapshot is waiting. The squelch flag is set by any
// alarm and re-armed only at a frame start, so frames are never cut short
// and then resumed. Assumes frame_bits_i is stable for the whole frame.
module ovs_bit_seq
    import ovs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  pend_valid_i,
    input  logic                  alarm_i,
    input  logic [FRAME_BITS-1:0] frame_bits_i,
    output logic                  take_o,
    output logic                  run_o,
    output logic                  squelch_o,
    output logic [IDX_W-1:0]      bit_idx_o,
    output logic                  sync_o,
    output logic                  data_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic             run_q;
    logic             sq_q;
    logic [IDX_W-1:0] idx_q;
    logic             boundary_w;
    logic             live_w;
    logic [IDX_W-1:0] sel_w;

    assign boundary_w = !run_q || (idx_q == LAST_IDX);
    assign take_o     = tick_i && boundary_w && pend_valid_i;

    // Advance the bit index per enable; restart or stop at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            idx_q <= '0;
        end else if (tick_i) begin
            if (boundary_w) begin
                run_q <= pend_valid_i;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Latch any alarm; re-evaluate only when a new frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       sq_q <= 1'b0;
        else if (take_o)  sq_q <= alarm_i;
        else if (alarm_i) sq_q <= 1'b1;
    end

    assign live_w    = run_q && !sq_q && !alarm_i;
    assign sel_w     = LAST_IDX - idx_q;
    assign sync_o    = live_w && (idx_q == '0);
    assign data_o    = live_w && frame_bits_i[sel_w];
    assign run_o     = run_q;
    assign squelch_o = sq_q;
    assign bit_idx_o = idx_q;

endmodule

// File: rtl/ovh_serial_fmt.sv
// Module: serial overhead byte output formatter (top).
// Joins the enable generator, snapshot store, slot map and sequencer.
// The three alarms are ORed into one squelch request. The serial enable
// leaves the block straight from the generator.
module ovh_serial_fmt
    import ovs_pkg::*;
#(
    parameter int BIT_DIV = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [NUM_LEAD-1:0][BYTE_W-1:0] lead_bytes_i,
    input  logic [BYTE_W-1:0]               d11_i,
    input  logic [BYTE_W-1:0]               d12_i,
    input  logic [BYTE_W-1:0]               s1_i,
    input  logic [BYTE_W-1:0]               e2_i,
    input  logic [BYTE_W-1:0]               b1_err_i,
    input  logic [CNT_W-1:0]                b2_bit_err_i,
    input  logic [CNT_W-1:0]                b2_blk_err_i,
    input  logic [BYTE_W-1:0]               m0_i,
    input  logic [BYTE_W-1:0]               m1_i,
    input  logic                            los_i,
    input  logic                            lof_i,
    input  logic                            sef_i,
    output logic                            ser_clk_en_o,
    output logic                            ser_sync_o,
    output logic                            ser_data_o
);

    logic                  tick_w;
    logic                  alarm_w;
    logic                  take_w;
    logic                  pend_valid_w;
    logic                  run_w;
    logic                  squelch_w;
    logic [IDX_W-1:0]      bit_idx_w;
    ovs_snap_t             snap_w;
    ovs_snap_t             active_w;
    logic [FRAME_BITS-1:0] frame_w;

    assign alarm_w = los_i || lof_i || sef_i;

    assign snap_w = '{lead:   lead_bytes_i,
                      d11:    d11_i,
                      d12:    d12_i,
                      s1:     s1_i,
                      e2:     e2_i,
                      b1:     b1_err_i,
                      b2_bit: b2_bit_err_i,
                      b2_blk: b2_blk_err_i,
                      m0:     m0_i,
                      m1:     m1_i};

    ovs_tick_gen #(.BIT_DIV(BIT_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    ovs_snapshot_buf u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .snap_i       (snap_w),
        .take_i       (take_w),
        .pend_valid_o (pend_valid_w),
        .active_o     (active_w)
    );

    ovs_slot_map u_map (
        .snap_i  (active_w),
        .frame_o (frame_w)
    );

    ovs_bit_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .pend_valid_i (pend_valid_w),
        .alarm_i      (alarm_w),
        .frame_bits_i (frame_w),
        .take_o       (take_w),
        .run_o        (run_w),
        .squelch_o    (squelch_w),
        .bit_idx_o    (bit_idx_w),
        .sync_o       (ser_sync_o),
        .data_o       (ser_data_o)
    );

    assign ser_clk_en_o = tick_w;

endmodule

// File: rtl/ovs_chk.sv
// Module: property checker for ovh_serial_fmt, attached with bind below.
// Watches the enable spacing, squelch, index walk and buffer stability.
module ovs_chk
    import ovs_pkg::*;
#(
    parameter int BIT_DIV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             alarm,
    input logic             run,
    input logic             squelch,
    input logic             take,
    input logic             pend_valid,
    input logic [IDX_W-1:0] bit_idx,
    input ovs_snap_t        active,
    input logic             sync_o,
    input logic             data_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    int   gap_q;
    logic seen_q;

    // Count clocks since the last enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= tick ? 0 : gap_q + 1;
            seen_q <= seen_q || tick;
        end
    end

    AST_CLK_EN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q == BIT_DIV - 1));                                // R1

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(bit_idx) && $stable(run)));                               // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && bit_idx != LAST_IDX) |=> (bit_idx == $past(bit_idx) + 1'b1)); // R2

    AST_SYNC_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (run && bit_idx == '0));                                          // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!sync_o && !data_o));                                              // R5

    AST_START_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(pend_valid));                                           // R5

    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(active));                                                  // R6

    AST_ALARM_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (!sync_o && !data_o));                                             // R7

    AST_SQUELCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (squelch && !take) |=> (!sync_o && !data_o));                                // R8

endmodule

bind ovh_serial_fmt ovs_chk #(.BIT_DIV(BIT_DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .alarm      (alarm_w),
    .run        (run_w),
    .squelch    (squelch_w),
    .take       (take_w),
    .pend_valid (pend_valid_w),
    .bit_idx    (bit_idx_w),
    .active     (active_w),
    .sync_o     (ser_sync_o),
    .data_o     (ser_data_o)
);

// File: tb/ovh_serial_fmt_tb.sv
// Scoreboard bench: the driver queues expected frames, each with the enable
// count at which its first bit is due; the monitor compares per enable.
module ovh_serial_fmt_tb;

    localparam int BIT_DIV = 2;
    localparam int FB      = 216;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [14:0][7:0]  lead_bytes_i = '0;
    logic [7:0]        d11_i = '0, d12_i = '0, s1_i = '0, e2_i = '0, b1_err_i = '0;
    logic [15:0]       b2_bit_err_i = '0, b2_blk_err_i = '0;
    logic [7:0]        m0_i = '0, m1_i = '0;
    logic              los_i = 1'b0, lof_i = 1'b0, sef_i = 1'b0;
    logic              ser_clk_en_o, ser_sync_o, ser_data_o;

    ovh_serial_fmt #(.BIT_DIV(BIT_DIV)) u_dut (
        .clk (clk), .rst_n (rst_n), .load_i (load_i),
        .lead_bytes_i (lead_bytes_i), .d11_i (d11_i), .d12_i (d12_i),
        .s1_i (s1_i), .e2_i (e2_i), .b1_err_i (b1_err_i),
        .b2_bit_err_i (b2_bit_err_i), .b2_blk_err_i (b2_blk_err_i),
        .m0_i (m0_i), .m1_i (m1_i), .los_i (los_i), .lof_i (lof_i),
        .sef_i (sef_i), .ser_clk_en_o (ser_clk_en_o),
        .ser_sync_o (ser_sync_o), .ser_data_o (ser_data_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          start;
        logic [FB-1:0] bits;
        logic        sync_exp;
        string       tag;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0, errors = 0;
    int            tick_no = 0;
    int            idle_bad = 0, clk_bad = 0, sync_seen = 0;
    bit            done = 1'b0;
    logic [FB-1:0] last_exp;

    // Monitor state
    exp_t cur_e;
    bit   in_fr = 1'b0;
    int   fj = 0, nbad = 0, bad_j = 0;
    logic bad_act = 1'b0, bad_exp = 1'b0;
    logic e_d, e_s;
    int   gap = 0;
    bit   gap_seen = 1'b0;

    task automatic check(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Expected frame built from the slot order in R3.
    function automatic logic [FB-1:0] build_frame();
        logic [FB-1:0] f = '0;
        for (int k = 0; k < 15; k++) f = {f[FB-9:0], lead_bytes_i[k]};
        f = {f[FB-9:0], d11_i};
        f = {f[FB-9:0], d12_i};
        f = {f[FB-9:0], s1_i};
        f = {f[FB-9:0], e2_i};
        f = {f[FB-9:0], b1_err_i};
        f = {f[FB-9:0], b2_bit_err_i[15:8]};
        f = {f[FB-9:0], b2_bit_err_i[7:0]};
        f = {f[FB-9:0], b2_blk_err_i[15:8]};
        f = {f[FB-9:0], b2_blk_err_i[7:0]};
        f = {f[FB-9:0], m0_i};
        f = {f[FB-9:0], m1_i};
        f = {f[FB-9:0], 8'h00};
        return f;
    endfunction

    function automatic logic [FB-1:0] squelch_from(input logic [FB-1:0] b, input int j0);
        logic [FB-1:0] r = b;
        for (int j = j0; j < FB; j++) r[FB-1-j] = 1'b0;
        return r;
    endfunction

    // Driver: set distinct inputs from a seed, then pulse load for one clock.
    task automatic load_snap(input int seed);
        for (int k = 0; k < 15; k++) lead_bytes_i[k] = 8'((seed * 37) + k * 29 + 1);
        d11_i        = 8'(seed + 8'h5A);
        d12_i        = 8'(seed ^ 8'hC3);
        s1_i         = 8'(seed * 3 + 8'h81);
        e2_i         = 8'(8'hF0 - seed);
        b1_err_i     = 8'(seed * 11);
        b2_bit_err_i = 16'(16'hA55A + seed * 16'h0123);
        b2_blk_err_i = 16'(16'h3CC3 ^ (seed * 16'h1111));
        m0_i         = 8'(seed + 8'h42);
        m1_i         = 8'(8'h99 ^ seed);
        last_exp     = build_frame();
        load_i = 1'b1;
        @(posedge clk);
        #1 load_i = 1'b0;
    endtask

    task automatic push_exp(input int start, input logic [FB-1:0] bits,
                            input logic sync_exp, input string tag);
        exp_t e;
        e.start = start; e.bits = bits; e.sync_exp = sync_exp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Wait until the given enable count has just been sampled.
    task automatic wait_to(input int n);
        while (tick_no < n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Monitor: one sample per enable, compared to the queued frame.
    always @(negedge clk) begin
        if (rst_n && ser_clk_en_o) begin
            if (!in_fr && sb_q.size() > 0 && tick_no == sb_q[0].start) begin
                cur_e = sb_q.pop_front();
                in_fr = 1'b1; fj = 0; nbad = 0;
            end
            if (in_fr) begin
                e_d = cur_e.bits[FB-1-fj];
                e_s = (fj == 0) && cur_e.sync_exp;
                if (ser_data_o !== e_d || ser_sync_o !== e_s) begin
                    if (nbad == 0) begin
                        bad_j = fj;
                        bad_act = (ser_data_o !== e_d) ? ser_data_o : ser_sync_o;
                        bad_exp = (ser_data_o !== e_d) ? e_d : e_s;
                    end
                    nbad++;
                end
                fj++;
                if (fj == FB) begin
                    checks++;
                    if (nbad != 0) begin
                        errors++;
                        $display("FAIL %s: frame at %0d, cycle %0d: actual %0b expected %0b (%0d bad)",
                                 cur_e.tag, cur_e.start, bad_j + 1, bad_act, bad_exp, nbad);
                    end
                    in_fr = 1'b0;
                end
            end else if (ser_sync_o !== 1'b0 || ser_data_o !== 1'b0) begin
                idle_bad++;
            end
            if (ser_sync_o === 1'b1) sync_seen++;
            tick_no++;
        end
    end

    // Enable spacing monitor (R1).
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk_en_o) begin
                if (gap_seen && gap != BIT_DIV) clk_bad++;
                gap = 1; gap_seen = 1'b1;
            end else begin
                gap++;
            end
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        check("R9 sync in reset", ser_sync_o === 1'b0, ser_sync_o, 0);
        check("R9 data in reset", ser_data_o === 1'b0, ser_data_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Normal frame, slot order and MSB-first bits.
        wait_to(5);
        load_snap(1);
        push_exp(tick_no + 1, last_exp, 1'b1, "R2 R3 frame A");

        // Two loads during A: the later one follows A without a gap.
        wait_to(60);  load_snap(2);
        wait_to(120); load_snap(3);
        push_exp(6 + FB, last_exp, 1'b1, "R6 frame C back-to-back");

        // Alarm mid-frame, cleared mid-frame.
        wait_to(470);
        load_snap(4);
        push_exp(471, squelch_from(last_exp, 40), 1'b1, "R7 frame D squelch");
        wait_to(511); los_i = 1'b1;
        wait_to(551); los_i = 1'b0;
        wait_to(600); load_snap(5);
        push_exp(471 + FB, last_exp, 1'b1, "R8 frame E after alarm");

        // Alarm pulse while idle has no effect on the next frame.
        wait_to(920); sef_i = 1'b1;
        wait_to(930); sef_i = 1'b0;
        wait_to(940); load_snap(6);
        push_exp(941, last_exp, 1'b1, "R8 frame F after idle alarm");

        // Alarm across a boundary silences the whole following frame.
        wait_to(1160); load_snap(7);
        push_exp(1161, squelch_from(last_exp, 200), 1'b1, "R7 frame G tail squelch");
        wait_to(1250); load_snap(8);
        push_exp(1161 + FB, '0, 1'b0, "R8 frame H silent");
        wait_to(1361); lof_i = 1'b1;
        wait_to(1387); lof_i = 1'b0;

        wait_to(1620);
        check("R5 idle outputs low", idle_bad == 0, idle_bad, 0);
        check("R1 enable spacing", clk_bad == 0, clk_bad, 0);
        check("R6 all frames emitted", sb_q.size() == 0, sb_q.size(), 0);
        check("R4 sync pulse count", sync_seen == 6, sync_seen, 6);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule